// File: doc/BRIEF.md
# Device Page Request Engine

This block sits on the device side of an address translation path. When a DMA access misses in the device's translation cache, the miss comes to this engine. The engine takes a free request-group tag, records the page, and sends a page request message carrying the page number and that tag toward the host. The host is expected to make the page resident and then answer with a group response that carries the same tag and a status.

A successful response for a waiting tag turns that tag into a pending retry. The engine then sends a fresh translation request for the recorded page, exactly once, and frees the tag when that request is accepted. A failed response frees the tag at once and reports a one-cycle fault with the page and tag, and no retry follows. A response whose tag has no group waiting is discarded and sets a sticky error flag. Up to 2**TAG_W groups can be outstanding at once, and new misses stall while every tag is in use.

Top module: `pgreq_engine`

## Requirements
- R1: After reset, miss_ready is 1 and preq_valid, xreq_valid, fault_valid and err_stray are all 0.
- R2: An accepted miss produces, on the following cycle, preq_valid with preq_page equal to miss_addr shifted right by PAGE_SHIFT and preq_tag equal to the tag allocated for it.
- R3: While preq_valid is high and preq_ready is low, preq_page and preq_tag hold steady and miss_ready stays low.
- R4: Tags are in use from miss acceptance until they are freed, and at most 2**TAG_W are in use at once. While all are in use, miss_ready is 0 and no new page request appears.
- R5: A success response (rsp_ok = 1) for a tag waiting on its response leads to exactly one translation request with that tag and the recorded page. The request is held until xreq_ready, and the tag is freed on acceptance.
- R6: A failure response (rsp_ok = 0) for a waiting tag raises fault_valid for one cycle on the next cycle, with fault_tag and fault_page of that group. The tag is freed and no translation request follows for it.
- R7: A response whose tag is not waiting on a response is dropped, with no fault and no translation request, and it sets err_stray. err_stray stays set until reset.
- R9: A miss is always given the lowest-numbered free tag.
- R8: When the translation request output is free, it loads the lowest-numbered tag pending a retry. The output holds that choice until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss offered |
| miss_ready | output | 1 | Miss accepted this cycle when high with miss_valid |
| miss_addr | input | ADDR_W | Address that missed |
| preq_valid | output | 1 | Page request message valid |
| preq_ready | input | 1 | Page request message taken |
| preq_page | output | ADDR_W-PAGE_SHIFT | Requested page number |
| preq_tag | output | TAG_W | Request-group tag |
| rsp_valid | input | 1 | Group response present (one cycle) |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_ok | input | 1 | 1 = page made resident, 0 = failure |
| xreq_valid | output | 1 | Retried translation request valid |
| xreq_ready | input | 1 | Translation request taken |
| xreq_page | output | ADDR_W-PAGE_SHIFT | Page to translate again |
| xreq_tag | output | TAG_W | Tag of the completed group |
| fault_valid | output | 1 | One-cycle fault report |
| fault_page | output | ADDR_W-PAGE_SHIFT | Page of the failed group |
| fault_tag | output | TAG_W | Tag of the failed group |
| err_stray | output | 1 | Sticky: a response matched no waiting group |

## Verification
The tag space is filled completely and then answered in three ways. First, every group gets a success response in descending order while the retry output is blocked. This separates the lock-then-lowest-first retry order from plain arrival order. Second, even tags fail and odd tags succeed, which tells the fault path apart from the retry path for each tag. A response is then sent to every tag while none is waiting, and a duplicate response is sent to a group whose retry is already pending; both check that dropping works and that the error flag stays set. A blocked request output shows the hold behaviour and the miss stall.

// File: rtl/pgreq_pkg.sv
`timescale 1ns/1ps
package pgreq_pkg;
   // Life cycle of one request-group tag.
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,  // free
      SLOT_WAIT  = 2'd1,  // page request sent or pending, awaiting response
      SLOT_RETRY = 2'd2,  // success seen, translation request not yet loaded
      SLOT_ISSUE = 2'd3   // translation request on the output
   } slot_state_e;
endpackage

// File: rtl/pgreq_first_set.sv
`timescale 1ns/1ps
// Priority pick over a request vector; LOW_FIRST selects the search direction.
module pgreq_first_set #(
   parameter int N         = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("pgreq_first_set: N must be at least 2");
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/pgreq_slot.sv
`timescale 1ns/1ps
// State and page storage for one request-group tag.
module pgreq_slot
   import pgreq_pkg::*;
#(
   parameter int PAGE_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [PAGE_W-1:0] alloc_page,
   input  logic              rsp_hit,
   input  logic              rsp_ok,
   input  logic              load_x,
   input  logic              issue_done,
   output slot_state_e       state,
   output logic [PAGE_W-1:0] page
);
   slot_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         SLOT_IDLE:  if (alloc)      state_nx = SLOT_WAIT;
         SLOT_WAIT:  if (rsp_hit)    state_nx = rsp_ok ? SLOT_RETRY : SLOT_IDLE;
         SLOT_RETRY: if (load_x)     state_nx = SLOT_ISSUE;
         SLOT_ISSUE: if (issue_done) state_nx = SLOT_IDLE;
         default:                    state_nx = SLOT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SLOT_IDLE;
         page  <= '0;
      end else begin
         state <= state_nx;
         if (alloc && state == SLOT_IDLE) page <= alloc_page;
      end
   end
endmodule

// File: rtl/pgreq_hold_reg.sv
`timescale 1ns/1ps
// Single-entry output register with valid/ready; contents frozen while stalled.
module pgreq_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         ready,
   output logic         open,
   output logic         valid,
   output logic [W-1:0] dout
);
   assign open = !valid || ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load && open) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pgreq_engine.sv
`timescale 1ns/1ps
module pgreq_engine
   import pgreq_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int PAGE_SHIFT = 12,
   parameter int TAG_W      = 3,
   localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
   localparam int NUM_TAGS  = 1 << TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              preq_valid,
   input  logic              preq_ready,
   output logic [PAGE_W-1:0] preq_page,
   output logic [TAG_W-1:0]  preq_tag,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   input  logic              rsp_ok,
   output logic              xreq_valid,
   input  logic              xreq_ready,
   output logic [PAGE_W-1:0] xreq_page,
   output logic [TAG_W-1:0]  xreq_tag,
   output logic              fault_valid,
   output logic [PAGE_W-1:0] fault_page,
   output logic [TAG_W-1:0]  fault_tag,
   output logic              err_stray
);
   localparam int MSG_W = TAG_W + PAGE_W;

   if (TAG_W < 1 || TAG_W > 6) begin : g_bad_tag
      $error("pgreq_engine: TAG_W must lie in 1..6");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("pgreq_engine: PAGE_SHIFT must lie in 1..ADDR_W-1");
   end

   slot_state_e         slot_state [NUM_TAGS];
   logic [PAGE_W-1:0]   slot_page  [NUM_TAGS];
   logic [NUM_TAGS-1:0] idle_vec, wait_vec, retry_vec, busy_vec;

   logic             free_any, rt_any;
   logic [TAG_W-1:0] free_idx, rt_idx;
   logic             preq_open, x_open, miss_fire, load_x;
   logic             rsp_match;
   logic [MSG_W-1:0] preq_din, preq_dout, x_din, x_dout;

   // ---------------- tag selection ----------------
   pgreq_first_set #(.N(NUM_TAGS), .LOW_FIRST(1'b1)) u_free_pick (
      .req   (idle_vec),
      .found (free_any),
      .idx   (free_idx)
   );

   pgreq_first_set #(.N(NUM_TAGS), .LOW_FIRST(1'b1)) u_retry_pick (
      .req   (retry_vec),
      .found (rt_any),
      .idx   (rt_idx)
   );

   assign miss_ready = free_any && preq_open;
   assign miss_fire  = miss_valid && miss_ready;
   assign load_x     = rt_any && x_open;
   assign rsp_match  = rsp_valid && wait_vec[rsp_tag];

   // ---------------- per-tag slots ----------------
   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
      logic alloc_t, hit_t, load_t, done_t;

      assign alloc_t = miss_fire && (free_idx == TAG_W'(t));
      assign hit_t   = rsp_valid && (rsp_tag == TAG_W'(t));
      assign load_t  = load_x && (rt_idx == TAG_W'(t));
      assign done_t  = xreq_valid && xreq_ready && (xreq_tag == TAG_W'(t));

      pgreq_slot #(.PAGE_W(PAGE_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (alloc_t),
         .alloc_page (miss_addr[ADDR_W-1:PAGE_SHIFT]),
         .rsp_hit    (hit_t),
         .rsp_ok     (rsp_ok),
         .load_x     (load_t),
         .issue_done (done_t),
         .state      (slot_state[t]),
         .page       (slot_page[t])
      );

      assign idle_vec[t]  = (slot_state[t] == SLOT_IDLE);
      assign wait_vec[t]  = (slot_state[t] == SLOT_WAIT);
      assign retry_vec[t] = (slot_state[t] == SLOT_RETRY);
      assign busy_vec[t]  = (slot_state[t] != SLOT_IDLE);
   end

   // ---------------- page request output ----------------
   assign preq_din = {free_idx, miss_addr[ADDR_W-1:PAGE_SHIFT]};

   pgreq_hold_reg #(.W(MSG_W)) u_preq_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (miss_fire),
      .din   (preq_din),
      .ready (preq_ready),
      .open  (preq_open),
      .valid (preq_valid),
      .dout  (preq_dout)
   );

   assign preq_tag  = preq_dout[MSG_W-1:PAGE_W];
   assign preq_page = preq_dout[PAGE_W-1:0];

   // ---------------- retried translation request output ----------------
   assign x_din = {rt_idx, slot_page[rt_idx]};

   pgreq_hold_reg #(.W(MSG_W)) u_xreq_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_x),
      .din   (x_din),
      .ready (xreq_ready),
      .open  (x_open),
      .valid (xreq_valid),
      .dout  (x_dout)
   );

   assign xreq_tag  = x_dout[MSG_W-1:PAGE_W];
   assign xreq_page = x_dout[PAGE_W-1:0];

   // ---------------- fault report and stray flag ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_valid <= 1'b0;
         fault_page  <= '0;
         fault_tag   <= '0;
         err_stray   <= 1'b0;
      end else begin
         fault_valid <= rsp_match && !rsp_ok;
         if (rsp_match && !rsp_ok) begin
            fault_page <= slot_page[rsp_tag];
            fault_tag  <= rsp_tag;
         end
         if (rsp_valid && !rsp_match) err_stray <= 1'b1;
      end
   end
endmodule

// File: rtl/pgreq_engine_chk.sv
`timescale 1ns/1ps
module pgreq_engine_chk #(
   parameter int TAG_W  = 3,
   parameter int PAGE_W = 28,
   localparam int NUM_TAGS = 1 << TAG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_ready,
   input logic              preq_valid,
   input logic              preq_ready,
   input logic [PAGE_W-1:0] preq_page,
   input logic [TAG_W-1:0]  preq_tag,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic              xreq_valid,
   input logic              xreq_ready,
   input logic [PAGE_W-1:0] xreq_page,
   input logic [TAG_W-1:0]  xreq_tag,
   input logic              fault_valid,
   input logic              err_stray,
   input logic [NUM_TAGS-1:0] busy_vec
);
   AST_PREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (preq_valid && !preq_ready) |=> (preq_valid && $stable(preq_page) && $stable(preq_tag))); // R3

   AST_PREQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (preq_valid && !preq_ready) |-> !miss_ready); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(busy_vec) == NUM_TAGS) |-> !miss_ready); // R4

   AST_XREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xreq_valid && !xreq_ready) |=> (xreq_valid && $stable(xreq_page) && $stable(xreq_tag))); // R5

   AST_XREQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      xreq_valid |-> busy_vec[xreq_tag]); // R5

   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> $past(rsp_valid && !rsp_ok)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_stray |=> err_stray); // R7
endmodule

bind pgreq_engine pgreq_engine_chk #(.TAG_W(TAG_W), .PAGE_W(PAGE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .miss_ready  (miss_ready),
   .preq_valid  (preq_valid),
   .preq_ready  (preq_ready),
   .preq_page   (preq_page),
   .preq_tag    (preq_tag),
   .rsp_valid   (rsp_valid),
   .rsp_ok      (rsp_ok),
   .xreq_valid  (xreq_valid),
   .xreq_ready  (xreq_ready),
   .xreq_page   (xreq_page),
   .xreq_tag    (xreq_tag),
   .fault_valid (fault_valid),
   .err_stray   (err_stray),
   .busy_vec    (busy_vec)
);

// File: tb/pgreq_engine_bench.sv
`timescale 1ns/1ps
module pgreq_engine_bench;
   localparam int ADDR_W = 40;
   localparam int SHIFT  = 12;
   localparam int TAG_W  = 3;
   localparam int PW     = ADDR_W - SHIFT;
   localparam int NT     = 1 << TAG_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic miss_valid = 1'b0, preq_ready = 1'b1, rsp_valid = 1'b0, rsp_ok = 1'b0, xreq_ready = 1'b1;
   logic [ADDR_W-1:0] miss_addr = '0;
   logic [TAG_W-1:0]  rsp_tag = '0;
   logic miss_ready, preq_valid, xreq_valid, fault_valid, err_stray;
   logic [PW-1:0]    preq_page, xreq_page, fault_page;
   logic [TAG_W-1:0] preq_tag, xreq_tag, fault_tag;

   always #10 clk = ~clk;   // 50 MHz

   pgreq_engine #(.ADDR_W(ADDR_W), .PAGE_SHIFT(SHIFT), .TAG_W(TAG_W)) u_pgreq_engine (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
      .preq_valid(preq_valid), .preq_ready(preq_ready), .preq_page(preq_page), .preq_tag(preq_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_ok(rsp_ok),
      .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_page(xreq_page), .xreq_tag(xreq_tag),
      .fault_valid(fault_valid), .fault_page(fault_page), .fault_tag(fault_tag),
      .err_stray(err_stray)
   );

   int n_chk = 0, n_bad = 0;
   int p_n = 0, x_n = 0, f_n = 0;
   int p_tag [64], x_tag [64];
   longint p_page [64], x_page [64];
   int cnt_x [NT], cnt_f [NT];
   longint f_page_by_tag [NT];

   task automatic check(input longint act, input longint exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   // Monitor: record completed handshakes at the falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (preq_valid && preq_ready && p_n < 64) begin
            p_tag[p_n] = int'(preq_tag); p_page[p_n] = longint'(preq_page); p_n++;
         end
         if (xreq_valid && xreq_ready) begin
            if (x_n < 64) begin x_tag[x_n] = int'(xreq_tag); x_page[x_n] = longint'(xreq_page); end
            x_n++;
            cnt_x[xreq_tag]++;
         end
         if (fault_valid) begin
            f_n++;
            cnt_f[fault_tag]++;
            f_page_by_tag[fault_tag] = longint'(fault_page);
         end
      end
   end

   function automatic longint page_of(input int round, input int k);
      return longint'(round) * 64'h10_0000 + longint'(k) * 64'h1357 + 64'hA5;
   endfunction

   task automatic clear_logs();
      p_n = 0; x_n = 0; f_n = 0;
      for (int i = 0; i < NT; i++) begin cnt_x[i] = 0; cnt_f[i] = 0; f_page_by_tag[i] = 0; end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; miss_valid = 0; rsp_valid = 0; preq_ready = 1; xreq_ready = 1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      clear_logs();
   endtask

   task automatic do_miss(input longint page, input int low);
      @(posedge clk); #1;
      miss_valid = 1'b1;
      miss_addr  = {page[PW-1:0], 12'(low)};
      @(negedge clk);
      while (!miss_ready) @(negedge clk);
      @(posedge clk); #1;
      miss_valid = 1'b0;
   endtask

   task automatic send_rsp(input int tag, input bit ok);
      @(posedge clk); #1;
      rsp_valid = 1'b1; rsp_tag = TAG_W'(tag); rsp_ok = ok;
      @(posedge clk); #1;
      rsp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int base_x;
      int last_tag;
      do_reset();
      @(negedge clk);
      // R1 reset state
      check(miss_ready, 1, "R1 miss_ready after reset");
      check(preq_valid, 0, "R1 preq_valid after reset");
      check(xreq_valid, 0, "R1 xreq_valid after reset");
      check(fault_valid, 0, "R1 fault_valid after reset");
      check(err_stray, 0, "R1 err_stray after reset");

      // ---- Fill all tags (R2, R9, R4) ----
      for (int k = 0; k < NT; k++) do_miss(page_of(1, k), k * 49);
      idle(3);
      check(p_n, NT, "R4 page requests for full fill");
      for (int k = 0; k < NT; k++) begin
         check(p_tag[k], k, $sformatf("R9 lowest free tag for miss %0d", k));
         check(p_page[k], page_of(1, k), $sformatf("R2 page of request %0d", k));
      end
      check(miss_ready, 0, "R4 miss_ready with all tags in use");
      @(posedge clk); #1;
      miss_valid = 1'b1; miss_addr = {page_of(9, 0)[PW-1:0], 12'h0};
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         check(miss_ready, 0, $sformatf("R4 stall cycle %0d", c));
      end
      @(posedge clk); #1 miss_valid = 1'b0;
      idle(2);
      check(p_n, NT, "R4 no request while full");

      // ---- Success in descending order, retry output blocked (R5, R8) ----
      @(posedge clk); #1 xreq_ready = 1'b0;
      for (int k = NT - 1; k >= 0; k--) send_rsp(k, 1'b1);
      idle(2);
      check(xreq_valid, 1, "R5 translation request raised");
      last_tag = int'(xreq_tag);
      check(last_tag, NT - 1, "R8 first loaded tag");
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check(xreq_tag, NT - 1, $sformatf("R5 tag held cycle %0d", c));
         check(xreq_page, page_of(1, NT - 1), $sformatf("R5 page held cycle %0d", c));
      end
      @(posedge clk); #1 xreq_ready = 1'b1;
      idle(3 * NT);
      check(x_n, NT, "R5 one translation request per group");
      for (int i = 0; i < NT; i++) begin
         int et;
         et = (i == 0) ? NT - 1 : i - 1;
         check(x_tag[i], et, $sformatf("R8 issue order slot %0d", i));
         check(x_page[i], page_of(1, et), $sformatf("R5 issue page slot %0d", i));
      end
      check(f_n, 0, "R6 no faults on success");
      check(miss_ready, 1, "R5 tags freed after accept");

      // ---- Mixed: even tags fail, odd succeed (R5, R6) ----
      clear_logs();
      for (int k = 0; k < NT; k++) do_miss(page_of(2, k), 0);
      idle(2);
      for (int k = 0; k < NT; k++) send_rsp(k, k[0]);
      idle(3 * NT);
      for (int k = 0; k < NT; k++) begin
         if (k[0]) begin
            check(cnt_x[k], 1, $sformatf("R5 retry count tag %0d", k));
            check(cnt_f[k], 0, $sformatf("R6 no fault tag %0d", k));
         end else begin
            check(cnt_x[k], 0, $sformatf("R6 no retry on failure tag %0d", k));
            check(cnt_f[k], 1, $sformatf("R6 fault count tag %0d", k));
            check(f_page_by_tag[k], page_of(2, k), $sformatf("R6 fault page tag %0d", k));
         end
      end
      check(miss_ready, 1, "R6 tags freed after mixed round");
      check(err_stray, 0, "R7 no stray on matched responses");

      // ---- Duplicate response while retry pending (R7) ----
      clear_logs();
      @(posedge clk); #1 xreq_ready = 1'b0;
      do_miss(page_of(3, 5), 7);
      idle(1);
      send_rsp(0, 1'b1);
      idle(2);
      check(xreq_valid, 1, "R5 retry pending for tag 0");
      send_rsp(0, 1'b1);
      idle(1);
      check(err_stray, 1, "R7 duplicate response flagged");
      @(posedge clk); #1 xreq_ready = 1'b1;
      idle(4);
      check(cnt_x[0], 1, "R7 duplicate gives no second retry");
      check(f_n, 0, "R7 duplicate gives no fault");
      idle(3);
      check(err_stray, 1, "R7 flag stays set");

      // ---- Reset clears flag; stray sweep over every tag (R1, R7) ----
      do_reset();
      @(negedge clk);
      check(err_stray, 0, "R1 err_stray cleared by reset");
      for (int k = 0; k < NT; k++) begin
         send_rsp(k, k[1]);
         @(negedge clk);
         check(err_stray, 1, $sformatf("R7 stray tag %0d flagged", k));
      end
      idle(3);
      check(x_n, 0, "R7 strays give no retry");
      check(f_n, 0, "R7 strays give no fault");
      check(miss_ready, 1, "R7 strays allocate nothing");

      // ---- Request output blocked (R3) ----
      clear_logs();
      @(posedge clk); #1 preq_ready = 1'b0;
      do_miss(page_of(4, 3), 1);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check(preq_valid, 1, $sformatf("R3 valid held cycle %0d", c));
         check(preq_tag, 0, $sformatf("R3 tag held cycle %0d", c));
         check(preq_page, page_of(4, 3), $sformatf("R3 page held cycle %0d", c));
         check(miss_ready, 0, $sformatf("R3 miss stalled cycle %0d", c));
      end
      @(posedge clk); #1 preq_ready = 1'b1;
      idle(2);
      check(p_n, 1, "R3 single request after release");
      check(miss_ready, 1, "R3 miss_ready back after release");

      base_x = x_n;
      check(base_x, 0, "R5 no spurious retry at end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule